// File: doc/BRIEF.md
# Auto-Ranging Capture Sequencer

This block runs an external input-capture unit through up to three measurements of a periodic input and picks the counter prescaler and the event prescaler. The goal is the best resolution that still fits a given timeout window. Each run proceeds as follows:

1. A start request latches the timeout, given in counter-clock ticks, and the maximum counter value.
2. The block derives a coarse prescaler and runs a first capture.
3. If that capture shows the counter range is mostly unused, the block divides the prescaler down and captures again.
4. It then picks how many input edges one capture should span. If that count is above one, it runs a final capture with both capture channels set to that setting.

The result is a period and a duty value normalised to one input cycle, both in prescaled counter ticks, together with the two prescaler settings that were used.

The capture unit is reached through a request pulse, a prescaler setting, an event setting, and a completion or timeout response that carries the raw period and duty counts. All divisions (initial prescaler, scale factor, rescaled prescaler) share one iterative divider that produces one quotient bit per cycle. Converting the result to time units is left to the consumer.

Top module: `capseq_top`

## Requirements
- R1: A start while `chan_busy_i` is high issues no capture request. The next cycle it raises `done_o` with `err_busy_o` = 1, `err_tmo_o` = 0, and `period_o` and `duty_o` at zero.
- R2: The first capture request carries event setting 0. Its prescaler is the smallest p for which floor(timeout/(p+1)) <= max, which equals floor(timeout/(max+1)), capped at `PSC_MAX`.
- R3: Let span = max - `MARGIN` (or 1 when max <= `MARGIN`) and P1 = the first raw period. Then scale = span / min(span, P1). If the first prescaler is nonzero and scale > 1, a second request is issued with prescaler floor(psc/scale) and event setting 0.
- R4: No second request is issued when the first prescaler is 0 or when scale <= 1.
- R5: A first raw period of zero sets scale to max.
- R6: The event code c is the first value of 0, 1, 2 that meets either condition below; if none does, c is 3. The conditions use P and psc, the latest raw period and prescaler:
  - P >= span >> (c+1)
  - P * (psc+1) >= timeout >> (c+2)
- R7: A nonzero event code causes one more capture request with that code on `cap_evpsc_o` and the prescaler of the last pass. Code 0 ends the run without it.
- R8: After the event-code pass, if duty >= P >> c, the reported duty is (P >> c) - (P - duty), modulo 2^CW. Otherwise the raw duty is reported.
- R9: The reported period is ceil(P / 2^c). `psc_o` and `evpsc_o` report the prescaler and event code of the last pass.
- R10: A capture timeout on any pass ends the run at once. It issues no further request and raises `done_o` with `err_tmo_o` = 1 and `period_o` and `duty_o` at zero.
- R11: `done_o` is high for exactly one cycle per run. In that cycle `cap_psc_o` and `cap_evpsc_o` read zero. After reset all outputs are zero.
- R12: A start while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start a measurement run (honoured only when idle) |
| timeout_ticks_i | input | TW | Timeout window in counter-clock ticks |
| max_count_i | input | CW | Maximum counter value |
| chan_busy_i | input | 1 | Another timer channel is active |
| cap_req_o | output | 1 | One-cycle capture request |
| cap_psc_o | output | PW | Counter prescaler for the capture unit |
| cap_evpsc_o | output | EVW | Event prescaler code for both capture channels |
| cap_done_i | input | 1 | Capture finished, raw values valid |
| cap_tmo_i | input | 1 | Capture timed out |
| cap_period_i | input | CW | Raw period count |
| cap_duty_i | input | CW | Raw duty count |
| done_o | output | 1 | Run finished (one cycle) |
| err_busy_o | output | 1 | Run rejected because a channel was busy |
| err_tmo_o | output | 1 | Run ended by a capture timeout |
| period_o | output | CW | Period per input cycle, prescaled ticks |
| duty_o | output | CW | Duty per input cycle, prescaled ticks |
| psc_o | output | PW | Counter prescaler of the final pass |
| evpsc_o | output | EVW | Event code of the final pass |

## Verification
A wrong prescaler or scale quotient shows up on `cap_psc_o` at the very next capture request, a few dozen cycles after the division starts. It therefore does not wait for the final result. A wrong event-code choice shows as a missing or extra third request, or a wrong `cap_evpsc_o`, right after the last division. Errors in the duty fix-up or the period ceiling appear only in the `done_o` cycle. The bench therefore checks every request's settings as it arrives and checks the result values at completion.

// File: rtl/capseq_pkg.sv
// Shared types for the capture sequencer.
// Assumes nothing beyond a SystemVerilog-2017 compiler.
package capseq_pkg;

    // Sequencer control states
    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV_PSC,
        S_WAIT,
        S_DIV_SCALE,
        S_DIV_PSC2,
        S_EVSEL
    } seq_state_t;

    // Which measurement pass is outstanding
    typedef enum logic [1:0] {
        PASS_COARSE,
        PASS_RESCALE,
        PASS_FINE
    } pass_t;

endpackage

// File: rtl/capseq_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// start_i loads the operands; done_o pulses W cycles later with quot_o valid.
// Assumes the divisor is nonzero; quot_o holds until the next start.
module capseq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);
    localparam int CNTW = $clog2(W + 1);

    logic [W:0]      rem_q;
    logic [W-1:0]    quo_q;
    logic [W-1:0]    dvs_q;
    logic [CNTW-1:0] cnt_q;
    logic            run_q;
    logic [W:0]      shf_w;
    logic            fits_w;

    // Partial remainder shifted left with the next dividend bit
    assign shf_w  = {rem_q[W-1:0], quo_q[W-1]};
    assign fits_w = (shf_w >= {1'b0, dvs_q});
    assign quot_o = quo_q;

    // Load operands, then do one subtract-or-keep step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                dvs_q <= divisor_i;
                cnt_q <= CNTW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= fits_w ? (shf_w - {1'b0, dvs_q}) : shf_w;
                quo_q <= {quo_q[W-2:0], fits_w};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNTW'(1)) begin
                    run_q  <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/capseq_evsel.sv
// Event-prescaler code selector, purely combinational.
// Step c is taken when the period already fills span>>(c+1), or when
// the elapsed ticks period*(psc+1) reach timeout>>(c+2).
// The lowest step taken wins; with none taken the code is EV_MAX.
module capseq_evsel #(
    parameter int CW     = 16,
    parameter int PW     = 16,
    parameter int TW     = 32,
    parameter int EV_MAX = 3,
    parameter int EVW    = 2
) (
    input  logic [CW-1:0]  period_i,
    input  logic [PW-1:0]  psc_i,
    input  logic [TW-1:0]  timeout_i,
    input  logic [CW-1:0]  span_i,
    output logic [EVW-1:0] code_o
);
    localparam int XW = CW + PW + TW;

    logic [XW-1:0]     elapsed_w;
    logic [EV_MAX-1:0] hit_w;

    // Counter ticks spent by one measured period
    assign elapsed_w = XW'(period_i) * (XW'(psc_i) + XW'(1));

    // One stop condition per candidate code
    for (genvar c = 0; c < EV_MAX; c++) begin : g_step
        assign hit_w[c] = (period_i >= (span_i >> (c + 1)))
                       || (elapsed_w >= XW'(timeout_i >> (c + 2)));
    end

    // Priority pick of the lowest code whose condition holds
    always_comb begin
        code_o = EVW'(EV_MAX);
        for (int c = EV_MAX - 1; c >= 0; c--) begin
            if (hit_w[c]) code_o = EVW'(c);
        end
    end
endmodule

// File: rtl/capseq_top.sv
// Auto-ranging capture sequencer.
// Runs up to three capture passes: coarse, prescaler rescale, event refinement.
// Assumes max_count_i > MARGIN for meaningful scaling (span saturates at 1),
// TW > CW, and a capture unit that answers every request with exactly one
// cap_done_i or cap_tmo_i pulse.
module capseq_top
    import capseq_pkg::*;
#(
    parameter int          CW      = 16,
    parameter int          PW      = 16,
    parameter int          TW      = 32,
    parameter int          MARGIN  = 4096,
    parameter int          EV_MAX  = 3,
    parameter int unsigned PSC_MAX = 65535,
    parameter int          EVW     = $clog2(EV_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [TW-1:0]  timeout_ticks_i,
    input  logic [CW-1:0]  max_count_i,
    input  logic           chan_busy_i,
    output logic           cap_req_o,
    output logic [PW-1:0]  cap_psc_o,
    output logic [EVW-1:0] cap_evpsc_o,
    input  logic           cap_done_i,
    input  logic           cap_tmo_i,
    input  logic [CW-1:0]  cap_period_i,
    input  logic [CW-1:0]  cap_duty_i,
    output logic           done_o,
    output logic           err_busy_o,
    output logic           err_tmo_o,
    output logic [CW-1:0]  period_o,
    output logic [CW-1:0]  duty_o,
    output logic [PW-1:0]  psc_o,
    output logic [EVW-1:0] evpsc_o
);
    localparam int DW = TW;

    seq_state_t     state_q;
    pass_t          pass_q;
    logic [TW-1:0]  tmo_q;
    logic [CW-1:0]  max_q;
    logic [PW-1:0]  psc_q;
    logic [EVW-1:0] ev_q;
    logic [CW-1:0]  per_q;
    logic [CW-1:0]  dut_q;

    logic           div_go_q;
    logic [DW-1:0]  div_a_q;
    logic [DW-1:0]  div_b_q;
    logic           div_done_w;
    logic [DW-1:0]  div_q_w;

    logic [CW-1:0]  span_w;
    logic [CW-1:0]  lim_w;
    logic [PW-1:0]  psc_clamp_w;
    logic [EVW-1:0] ev_sel_w;
    logic [CW-1:0]  p_shr_w;
    logic [CW-1:0]  d_fix_w;
    logic [CW:0]    p_sum_w;
    logic [CW-1:0]  p_ceil_w;

    // Usable counter span after the safety margin (never zero)
    assign span_w = (max_q > CW'(MARGIN)) ? (max_q - CW'(MARGIN)) : CW'(1);

    // Divisor of the scale computation: min(span, raw period)
    assign lim_w = (cap_period_i < span_w) ? cap_period_i : span_w;

    // Initial prescaler quotient limited to the largest allowed value
    assign psc_clamp_w = (div_q_w > DW'(PSC_MAX)) ? PW'(PSC_MAX) : div_q_w[PW-1:0];

    // Final-pass period per input cycle, floor and ceiling
    assign p_shr_w  = cap_period_i >> ev_q;
    assign p_sum_w  = {1'b0, cap_period_i} + (((CW+1)'(1) << ev_q) - (CW+1)'(1));
    assign p_ceil_w = CW'(p_sum_w >> ev_q);

    // Duty fix-up for captures that started on the high phase
    assign d_fix_w = (cap_duty_i >= p_shr_w) ? (p_shr_w - (cap_period_i - cap_duty_i))
                                             : cap_duty_i;

    capseq_div #(.W(DW)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_go_q),
        .dividend_i (div_a_q),
        .divisor_i  (div_b_q),
        .done_o     (div_done_w),
        .quot_o     (div_q_w)
    );

    capseq_evsel #(
        .CW(CW), .PW(PW), .TW(TW), .EV_MAX(EV_MAX), .EVW(EVW)
    ) u_evsel (
        .period_i  (per_q),
        .psc_i     (psc_q),
        .timeout_i (tmo_q),
        .span_i    (span_w),
        .code_o    (ev_sel_w)
    );

    // Sequencer: divisions, capture requests, result formation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            pass_q      <= PASS_COARSE;
            tmo_q       <= '0;
            max_q       <= '0;
            psc_q       <= '0;
            ev_q        <= '0;
            per_q       <= '0;
            dut_q       <= '0;
            div_go_q    <= 1'b0;
            div_a_q     <= '0;
            div_b_q     <= '0;
            cap_req_o   <= 1'b0;
            cap_psc_o   <= '0;
            cap_evpsc_o <= '0;
            done_o      <= 1'b0;
            err_busy_o  <= 1'b0;
            err_tmo_o   <= 1'b0;
            period_o    <= '0;
            duty_o      <= '0;
            psc_o       <= '0;
            evpsc_o     <= '0;
        end else begin
            done_o    <= 1'b0;
            div_go_q  <= 1'b0;
            cap_req_o <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        period_o   <= '0;
                        duty_o     <= '0;
                        psc_o      <= '0;
                        evpsc_o    <= '0;
                        err_tmo_o  <= 1'b0;
                        err_busy_o <= chan_busy_i;
                        if (chan_busy_i) begin
                            done_o <= 1'b1;
                        end else begin
                            tmo_q    <= timeout_ticks_i;
                            max_q    <= max_count_i;
                            div_a_q  <= timeout_ticks_i;
                            div_b_q  <= DW'(max_count_i) + DW'(1);
                            div_go_q <= 1'b1;
                            state_q  <= S_DIV_PSC;
                        end
                    end
                end
                S_DIV_PSC: begin
                    if (div_done_w) begin
                        psc_q       <= psc_clamp_w;
                        ev_q        <= '0;
                        pass_q      <= PASS_COARSE;
                        cap_req_o   <= 1'b1;
                        cap_psc_o   <= psc_clamp_w;
                        cap_evpsc_o <= '0;
                        state_q     <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (cap_tmo_i) begin
                        err_tmo_o   <= 1'b1;
                        done_o      <= 1'b1;
                        cap_psc_o   <= '0;
                        cap_evpsc_o <= '0;
                        state_q     <= S_IDLE;
                    end else if (cap_done_i) begin
                        per_q <= cap_period_i;
                        dut_q <= cap_duty_i;
                        case (pass_q)
                            PASS_COARSE: begin
                                if (psc_q == '0) begin
                                    state_q <= S_EVSEL;
                                end else if (cap_period_i == '0) begin
                                    if (max_q > CW'(1)) begin
                                        div_a_q  <= DW'(psc_q);
                                        div_b_q  <= DW'(max_q);
                                        div_go_q <= 1'b1;
                                        state_q  <= S_DIV_PSC2;
                                    end else begin
                                        state_q  <= S_EVSEL;
                                    end
                                end else begin
                                    div_a_q  <= DW'(span_w);
                                    div_b_q  <= DW'(lim_w);
                                    div_go_q <= 1'b1;
                                    state_q  <= S_DIV_SCALE;
                                end
                            end
                            PASS_RESCALE: begin
                                state_q <= S_EVSEL;
                            end
                            default: begin
                                period_o    <= p_ceil_w;
                                duty_o      <= d_fix_w;
                                psc_o       <= psc_q;
                                evpsc_o     <= ev_q;
                                done_o      <= 1'b1;
                                cap_psc_o   <= '0;
                                cap_evpsc_o <= '0;
                                state_q     <= S_IDLE;
                            end
                        endcase
                    end
                end
                S_DIV_SCALE: begin
                    if (div_done_w) begin
                        if (div_q_w > DW'(1)) begin
                            div_a_q  <= DW'(psc_q);
                            div_b_q  <= div_q_w;
                            div_go_q <= 1'b1;
                            state_q  <= S_DIV_PSC2;
                        end else begin
                            state_q  <= S_EVSEL;
                        end
                    end
                end
                S_DIV_PSC2: begin
                    if (div_done_w) begin
                        psc_q       <= div_q_w[PW-1:0];
                        pass_q      <= PASS_RESCALE;
                        cap_req_o   <= 1'b1;
                        cap_psc_o   <= div_q_w[PW-1:0];
                        cap_evpsc_o <= '0;
                        state_q     <= S_WAIT;
                    end
                end
                S_EVSEL: begin
                    if (ev_sel_w == '0) begin
                        period_o    <= per_q;
                        duty_o      <= dut_q;
                        psc_o       <= psc_q;
                        evpsc_o     <= '0;
                        done_o      <= 1'b1;
                        cap_psc_o   <= '0;
                        cap_evpsc_o <= '0;
                        state_q     <= S_IDLE;
                    end else begin
                        ev_q        <= ev_sel_w;
                        pass_q      <= PASS_FINE;
                        cap_req_o   <= 1'b1;
                        cap_psc_o   <= psc_q;
                        cap_evpsc_o <= ev_sel_w;
                        state_q     <= S_WAIT;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/capseq_chk.sv
// Port-level protocol checks for capseq_top, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module capseq_chk #(
    parameter int CW  = 16,
    parameter int PW  = 16,
    parameter int EVW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cap_req_o,
    input logic           done_o,
    input logic           err_busy_o,
    input logic           err_tmo_o,
    input logic [CW-1:0]  period_o,
    input logic [CW-1:0]  duty_o,
    input logic [PW-1:0]  cap_psc_o,
    input logic [EVW-1:0] cap_evpsc_o
);
    // Completion lasts a single cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Capture configuration is cleared when the run completes
    p_cfg_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cap_psc_o == '0 && cap_evpsc_o == '0));

    // Capture requests are single-cycle pulses
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req_o |=> !cap_req_o);

    // A busy rejection comes with completion and no result
    p_busy_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_busy_o) |-> (done_o && !err_tmo_o && period_o == '0 && duty_o == '0));

    // A timeout ending carries no result
    p_tmo_noresult_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_tmo_o) |-> (period_o == '0 && duty_o == '0 && !err_busy_o));

    // No request is issued in the completion cycle
    p_req_not_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cap_req_o |-> !done_o);
endmodule

bind capseq_top capseq_chk #(.CW(CW), .PW(PW), .EVW(EVW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_req_o   (cap_req_o),
    .done_o      (done_o),
    .err_busy_o  (err_busy_o),
    .err_tmo_o   (err_tmo_o),
    .period_o    (period_o),
    .duty_o      (duty_o),
    .cap_psc_o   (cap_psc_o),
    .cap_evpsc_o (cap_evpsc_o)
);

// File: tb/tb_capseq_top.sv
// Self-checking bench: bench-side capture model plus reference sequence.
module tb_capseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] timeout_ticks_i = '0;
    logic [15:0] max_count_i = '0;
    logic        chan_busy_i = 1'b0;
    logic        cap_req_o;
    logic [15:0] cap_psc_o;
    logic [1:0]  cap_evpsc_o;
    logic        cap_done_i = 1'b0;
    logic        cap_tmo_i = 1'b0;
    logic [15:0] cap_period_i = '0;
    logic [15:0] cap_duty_i = '0;
    logic        done_o;
    logic        err_busy_o;
    logic        err_tmo_o;
    logic [15:0] period_o;
    logic [15:0] duty_o;
    logic [15:0] psc_o;
    logic [1:0]  evpsc_o;

    int checks = 0;
    int errors = 0;

    // Stimulus parameters of the current case
    longint unsigned T, MX, Tin, Hin;
    bit  hs;
    int  tmo_pass;
    // Expected values of the current case
    int  e_npass, e_err;
    longint unsigned e_psc[3], e_ev[3], e_per, e_dut, e_fpsc, e_fev;

    capseq_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .timeout_ticks_i(timeout_ticks_i), .max_count_i(max_count_i),
        .chan_busy_i(chan_busy_i), .cap_req_o(cap_req_o),
        .cap_psc_o(cap_psc_o), .cap_evpsc_o(cap_evpsc_o),
        .cap_done_i(cap_done_i), .cap_tmo_i(cap_tmo_i),
        .cap_period_i(cap_period_i), .cap_duty_i(cap_duty_i),
        .done_o(done_o), .err_busy_o(err_busy_o), .err_tmo_o(err_tmo_o),
        .period_o(period_o), .duty_o(duty_o), .psc_o(psc_o), .evpsc_o(evpsc_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raw period the capture unit would return
    function automatic longint unsigned cap_per(longint unsigned psc, longint unsigned ev);
        return ((Tin << ev) / (psc + 1)) & 64'hFFFF;
    endfunction

    // Raw duty; a high-phase start stretches it when events are prescaled
    function automatic longint unsigned cap_dut(longint unsigned psc, longint unsigned ev);
        if (hs && ev != 0)
            return (((Tin << ev) - (Tin - Hin)) / (psc + 1)) & 64'hFFFF;
        return (Hin / (psc + 1)) & 64'hFFFF;
    endfunction

    // Reference sequence built directly from the requirements
    task automatic ref_model();
        longint unsigned psc, dv, m, P, D, scale, code;
        psc = 0;
        dv  = T;
        while (dv > MX && psc < 65535) begin
            psc++;
            dv = T / (psc + 1);
        end
        e_npass  = 1;
        e_psc[0] = psc;
        e_ev[0]  = 0;
        P = cap_per(psc, 0);
        D = cap_dut(psc, 0);
        m = (MX > 4096) ? MX - 4096 : 1;
        scale = (P == 0) ? MX : m / ((m < P) ? m : P);
        if (psc != 0 && scale > 1) begin
            psc = psc / scale;
            e_psc[e_npass] = psc;
            e_ev[e_npass]  = 0;
            e_npass++;
            P = cap_per(psc, 0);
            D = cap_dut(psc, 0);
        end
        code = 3;
        for (int c = 0; c < 3; c++) begin
            if (P >= (m >> (c + 1)) || P * (psc + 1) >= (T >> (c + 2))) begin
                code = c;
                break;
            end
        end
        if (code != 0) begin
            e_psc[e_npass] = psc;
            e_ev[e_npass]  = code;
            e_npass++;
            P = cap_per(psc, code);
            D = cap_dut(psc, code);
            if (D >= (P >> code)) D = ((P >> code) - (P - D)) & 64'hFFFF;
        end
        e_per  = (P + (64'd1 << code) - 1) >> code;
        e_dut  = D;
        e_fpsc = psc;
        e_fev  = code;
        e_err  = (tmo_pass >= 1 && tmo_pass <= e_npass) ? 1 : 0;
    endtask

    // One run: start, serve capture requests, check the outcome
    task automatic run_case(input bit busy, input bit midstart);
        int nreq = 0;
        int resp = -1;
        bit fin = 0;
        longint unsigned rq_psc = 0, rq_ev = 0;
        if (!busy) ref_model();
        @(negedge clk);
        timeout_ticks_i = T[31:0];
        max_count_i     = MX[15:0];
        chan_busy_i     = busy;
        start_i         = 1'b1;
        for (int cyc = 0; cyc < 6000 && !fin; cyc++) begin
            @(negedge clk);
            start_i = 1'b0;
            chan_busy_i = 1'b0;
            cap_done_i = 1'b0;
            cap_tmo_i  = 1'b0;
            if (done_o) begin
                fin = 1;
            end else begin
                if (cap_req_o) begin
                    nreq++;
                    rq_psc = cap_psc_o;
                    rq_ev  = cap_evpsc_o;
                    if (busy) chk("R1 request while busy", nreq, 0);
                    else if (nreq <= e_npass) begin
                        chk(nreq == 1 ? "R2 first psc" : (nreq == 2 && e_ev[1] == 0) ? "R3 rescaled psc" : "R7 psc",
                            rq_psc, e_psc[nreq-1]);
                        chk(nreq < e_npass || e_ev[nreq-1] == 0 ? "R2 ev zero" : "R7 ev code", rq_ev, e_ev[nreq-1]);
                    end
                    resp = 1 + int'($urandom % 5);
                    if (midstart && nreq == 1) begin
                        start_i = 1'b1;
                        timeout_ticks_i = 32'd7;
                    end
                end else if (resp > 0) begin
                    resp--;
                end
                if (resp == 0) begin
                    if (nreq == tmo_pass) begin
                        cap_tmo_i = 1'b1;
                    end else begin
                        cap_done_i   = 1'b1;
                        cap_period_i = 16'(cap_per(rq_psc, rq_ev));
                        cap_duty_i   = 16'(cap_dut(rq_psc, rq_ev));
                    end
                    resp = -1;
                end
            end
        end
        if (!fin) begin
            chk("R11 done never seen (watchdog)", 0, 1);
        end else if (busy) begin
            chk("R1 busy error", err_busy_o, 1);
            chk("R1 no timeout flag", err_tmo_o, 0);
            chk("R1 period zero", period_o, 0);
        end else if (e_err) begin
            chk("R10 timeout flag", err_tmo_o, 1);
            chk("R10 requests stop at timeout", nreq, tmo_pass);
            chk("R10 period zero", period_o, 0);
            chk("R10 duty zero", duty_o, 0);
        end else begin
            chk(midstart ? "R12 pass count" : "R4 R6 pass count", nreq, e_npass);
            chk("R9 period", period_o, e_per);
            chk("R8 duty", duty_o, e_dut);
            chk("R9 final psc", psc_o, e_fpsc);
            chk("R6 final event code", evpsc_o, e_fev);
            chk("R1 no busy flag", err_busy_o, 0);
        end
        chk("R11 config cleared", {cap_psc_o, cap_evpsc_o}, 0);
        @(negedge clk);
        chk("R11 done one cycle", done_o, 0);
    endtask

    // Global watchdog: a hung run still reaches the summary
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        hs = 0; tmo_pass = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset done", done_o, 0);
        chk("R11 reset request", cap_req_o, 0);
        chk("R11 reset results", {period_o, duty_o, psc_o}, 0);

        // R1: busy rejection
        T = 100000; MX = 65535; Tin = 1000; Hin = 300;
        run_case(1'b1, 1'b0);
        // R4: timeout fits, prescaler stays 0
        T = 60000; MX = 65535; Tin = 40000; Hin = 10000;
        run_case(1'b0, 1'b0);
        // R4: large period, scale 1, no rescale
        T = 2000000; MX = 65535; Tin = 1900000; Hin = 900000;
        run_case(1'b0, 1'b0);
        // R5: zero period
        T = 3000000; MX = 65535; Tin = 0; Hin = 0;
        run_case(1'b0, 1'b0);
        // R3 R7 R8: rescale then event refinement with high-phase start
        T = 1048576; MX = 65535; Tin = 17000; Hin = 5000; hs = 1;
        run_case(1'b0, 1'b0);
        // R9: same with low-phase start (plain duty, ceiling period)
        T = 1048576; MX = 65535; Tin = 17001; Hin = 4000; hs = 0;
        run_case(1'b0, 1'b0);
        // R2: prescaler capped
        T = 64'hFFFFFFFF; MX = 8192; Tin = 3000000; Hin = 1000000;
        run_case(1'b0, 1'b0);
        // R10: timeout on first and on last pass
        T = 1048576; MX = 65535; Tin = 17000; Hin = 5000; tmo_pass = 1;
        run_case(1'b0, 1'b0);
        tmo_pass = 3;
        run_case(1'b0, 1'b0);
        tmo_pass = 0;
        // R12: start during a run is ignored
        T = 1048576; MX = 65535; Tin = 17000; Hin = 5000;
        run_case(1'b0, 1'b1);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            MX  = 8192 + ($urandom % 57344);
            T   = 1 + ($urandom % (1 << 26));
            Tin = $urandom % 300000;
            Hin = (Tin == 0) ? 0 : $urandom % (Tin + 1);
            hs  = $urandom % 2;
            tmo_pass = ($urandom % 6 == 0) ? 1 + int'($urandom % 3) : 0;
            run_case(1'b0, 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule